// File: doc/BRIEF.md
# Converter Power-Down and Start-Up Sequencer

This block runs the digital side of an audio converter's shutdown and restart. An active-low power-down request holds the converter in its off state and keeps the decimation filter in reset. The request is accepted only after it has stayed low for a minimum number of system clocks. Once it is released, the block counts a fixed number of rising edges of the frame clock, so that the analog front end can settle. Until that count completes, the sample path is forced to zero and marked invalid.

The same sequencer decides when the automatic level control may act and which gain reaches the gain stage. The level control runs only in the normal state, and only while its enable bit is set. At all other times the applied gain is the value the host last wrote, including any write made while the level control was running. The frame clock and the power-down pin are asynchronous, so both pass through synchronizers inside the block.

Top module: `pdseq_top`

## Requirements
- R1: While the system reset `rstN` is low, and at all times in the power-down state: `filterRst` is 1, `dataValid` is 0, `sampleOut` is 0 and `alcActive` is 0.
- R2: A low level on `pdnN` held for at least PDN_MIN_CYC system clocks (after synchronization) moves the block from any state into power-down. A shorter low pulse leaves the state, `dataValid` and `sampleOut` unchanged.
- R3: After `pdnN` goes high, `filterRst` drops to 0. `dataValid` stays 0 through the first INIT_FRAMES-1 rising edges of `frameClk` and becomes 1 within a few system clocks after the INIT_FRAMES-th rising edge.
- R4: `frameClk` edges seen during power-down are not counted. Entering power-down during the settling period discards the partial count, so a full INIT_FRAMES edges are needed again.
- R5: When `dataValid` is 1, `sampleOut` equals `sampleIn` one clock later. When `dataValid` is 0, `sampleOut` is 0.
- R6: `alcActive` is 1 only in the normal state while `alcEn` is 1. It is 0 during power-down and settling, whatever the value of `alcEn`.
- R7: While `alcActive` is 1, `appliedGain` follows `alcGain`. While it is 0, `appliedGain` holds the last value written by the host. A host write made while the level control is active takes effect at the moment the control stops.
- R8: A host gain write (`hostGainWe` = 1) is stored in every state, including power-down. The system reset clears the stored gain to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| pdnN | input | 1 | Active-low power-down request, asynchronous |
| frameClk | input | 1 | Frame (left/right) clock, asynchronous |
| hostGainWe | input | 1 | Host gain write strobe |
| hostGain | input | GAIN_W | Host gain value |
| alcEn | input | 1 | Level-control enable bit |
| alcGain | input | GAIN_W | Gain requested by the level-control loop |
| sampleIn | input | DATA_W | Sample from the decimation filter |
| filterRst | output | 1 | Decimation filter reset, high in power-down |
| dataValid | output | 1 | Output samples are valid |
| alcActive | output | 1 | Level control currently in charge of the gain |
| appliedGain | output | GAIN_W | Gain presented to the gain stage |
| sampleOut | output | DATA_W | Gated sample, zero when not valid |

## Verification
The bench builds the block with INIT_FRAMES = 6 and PDN_MIN_CYC = 4, and keeps the default widths. A short settling count lets a single run check every frame edge of an aborted start-up and of a complete one, including the exact edge at which data turns valid. The small minimum low time lets both sides of the acceptance threshold be tested: a two-clock glitch that must be ignored, and a ten-clock request that must be accepted.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [1:0] {
    ST_PDN    = 2'd0,
    ST_INIT   = 2'd1,
    ST_NORMAL = 2'd2
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic filterRst;
    logic outEnable;
    logic alcRun;
  } seqCtrl_t;

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
#(
  parameter int INIT_FRAMES = 516,
  parameter int PDN_MIN_CYC = 38,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pdnN,
  input  logic     frameClk,
  input  logic     alcEn,
  output seqCtrl_t ctrl
);

  localparam int CNT_W = (INIT_FRAMES > 1) ? $clog2(INIT_FRAMES) : 1;
  localparam int LOW_W = $clog2(PDN_MIN_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_FRAME = CNT_W'(INIT_FRAMES - 1);
  localparam logic [LOW_W-1:0] LOW_LIMIT  = LOW_W'(PDN_MIN_CYC);

  logic pdnSync, frameSync, framePrev, frameRise, pdnHeld;
  logic [LOW_W-1:0] lowCnt;
  logic [CNT_W-1:0] initCnt, initCntNext;
  seqState_t state, stateNext;

  pdseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uPdnSync (
    .clk(clk), .rstN(rstN), .d(pdnN), .q(pdnSync)
  );

  pdseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uFrameSync (
    .clk(clk), .rstN(rstN), .d(frameClk), .q(frameSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) framePrev <= 1'b0;
    else       framePrev <= frameSync;
  end

  assign frameRise = frameSync & ~framePrev;

  // Qualify the power-down request: it must stay low for PDN_MIN_CYC clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lowCnt <= LOW_LIMIT;
    else if (pdnSync)          lowCnt <= '0;
    else if (lowCnt < LOW_LIMIT) lowCnt <= lowCnt + 1'b1;
  end

  assign pdnHeld = (lowCnt == LOW_LIMIT);

  always_comb begin
    stateNext   = state;
    initCntNext = initCnt;
    unique case (state)
      ST_PDN: begin
        initCntNext = '0;
        if (pdnSync) stateNext = ST_INIT;
      end
      ST_INIT: begin
        if (pdnHeld) begin
          stateNext   = ST_PDN;
          initCntNext = '0;
        end else if (frameRise) begin
          if (initCnt == LAST_FRAME) begin
            stateNext   = ST_NORMAL;
            initCntNext = '0;
          end else begin
            initCntNext = initCnt + 1'b1;
          end
        end
      end
      ST_NORMAL: begin
        if (pdnHeld) stateNext = ST_PDN;
      end
      default: begin
        stateNext   = ST_PDN;
        initCntNext = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PDN;
      initCnt <= '0;
    end else begin
      state   <= stateNext;
      initCnt <= initCntNext;
    end
  end

  assign ctrl.filterRst = (state == ST_PDN);
  assign ctrl.outEnable = (state == ST_NORMAL);
  assign ctrl.alcRun    = (state == ST_NORMAL) && alcEn;

  // R2: an unqualified low pulse never forces power-down
  assert_short_low_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_PDN && pdnSync && lowCnt < LOW_LIMIT) |=> (state != ST_PDN));

  // R3: normal state is reached only from the last settling frame
  assert_no_early_normal_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INIT) |=> (state != ST_NORMAL || $past(initCnt) == LAST_FRAME));

  // R4: the settling counter stays in range
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    initCnt <= LAST_FRAME);

  // R4: leaving power-down always starts from a cleared count
  assert_count_cleared_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PDN) |=> (initCnt == '0));

endmodule

// File: rtl/pdseq_datapath.sv
module pdseq_datapath
  import pdseq_pkg::*;
#(
  parameter int GAIN_W = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic              hostGainWe,
  input  logic [GAIN_W-1:0] hostGain,
  input  logic [GAIN_W-1:0] alcGain,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              dataValid,
  output logic              alcActive,
  output logic [GAIN_W-1:0] appliedGain,
  output logic [DATA_W-1:0] sampleOut
);

  logic [GAIN_W-1:0] gainReg;

  // Host-written gain is retained across every state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           gainReg <= '0;
    else if (hostGainWe) gainReg <= hostGain;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid   <= 1'b0;
      alcActive   <= 1'b0;
      appliedGain <= '0;
      sampleOut   <= '0;
    end else begin
      dataValid   <= ctrl.outEnable;
      alcActive   <= ctrl.alcRun;
      appliedGain <= ctrl.alcRun ? alcGain : gainReg;
      sampleOut   <= ctrl.outEnable ? sampleIn : '0;
    end
  end

  // R6: level control only acts while data is valid
  assert_alc_needs_normal_R6: assert property (@(posedge clk) disable iff (!rstN)
    alcActive |-> dataValid);

  // R7: with the level control idle and no host write, the gain is held
  assert_gain_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!alcActive && !$past(alcActive) && !$past(hostGainWe, 2)) |-> $stable(appliedGain));

  // R1: the filter-reset strobe is never present together with a valid output
  assert_rst_blocks_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.filterRst |=> !dataValid);

endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int INIT_FRAMES = 516,
  parameter int PDN_MIN_CYC = 38,
  parameter int SYNC_STAGES = 2,
  parameter int GAIN_W      = 8,
  parameter int DATA_W      = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pdnN,
  input  logic              frameClk,
  input  logic              hostGainWe,
  input  logic [GAIN_W-1:0] hostGain,
  input  logic              alcEn,
  input  logic [GAIN_W-1:0] alcGain,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              filterRst,
  output logic              dataValid,
  output logic              alcActive,
  output logic [GAIN_W-1:0] appliedGain,
  output logic [DATA_W-1:0] sampleOut
);

  seqCtrl_t ctrl;

  pdseq_ctrl #(
    .INIT_FRAMES(INIT_FRAMES),
    .PDN_MIN_CYC(PDN_MIN_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .pdnN(pdnN), .frameClk(frameClk),
    .alcEn(alcEn), .ctrl(ctrl)
  );

  pdseq_datapath #(
    .GAIN_W(GAIN_W),
    .DATA_W(DATA_W)
  ) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .hostGainWe(hostGainWe), .hostGain(hostGain), .alcGain(alcGain),
    .sampleIn(sampleIn), .dataValid(dataValid), .alcActive(alcActive),
    .appliedGain(appliedGain), .sampleOut(sampleOut)
  );

  assign filterRst = ctrl.filterRst;

endmodule

// File: tb/sim_pdseq_top.sv
`timescale 1ns/1ps
module sim_pdseq_top;

  localparam int INIT_FRAMES = 6;
  localparam int PDN_MIN_CYC = 4;
  localparam int GAIN_W = 8;
  localparam int DATA_W = 24;
  localparam logic [DATA_W-1:0] SAMPLE = 24'hA5F00D;

  logic clk = 1'b0;
  logic rstN, pdnN, frameClk, hostGainWe, alcEn;
  logic [GAIN_W-1:0] hostGain, alcGain;
  logic [DATA_W-1:0] sampleIn;
  logic filterRst, dataValid, alcActive;
  logic [GAIN_W-1:0] appliedGain;
  logic [DATA_W-1:0] sampleOut;

  always #2 clk = ~clk;

  pdseq_top #(
    .INIT_FRAMES(INIT_FRAMES), .PDN_MIN_CYC(PDN_MIN_CYC),
    .GAIN_W(GAIN_W), .DATA_W(DATA_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .pdnN(pdnN), .frameClk(frameClk),
    .hostGainWe(hostGainWe), .hostGain(hostGain), .alcEn(alcEn),
    .alcGain(alcGain), .sampleIn(sampleIn), .filterRst(filterRst),
    .dataValid(dataValid), .alcActive(alcActive),
    .appliedGain(appliedGain), .sampleOut(sampleOut)
  );

  typedef struct {
    string             tag;
    logic              fr;
    logic              vld;
    logic [DATA_W-1:0] smp;
    logic [GAIN_W-1:0] gain;
    logic              alc;
  } exp_t;

  exp_t expQ[$];
  event sampleNow;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: queue the expectation, then wake the monitor
  task automatic expect_out(input string tag, input logic fr, input logic vld,
                            input logic [GAIN_W-1:0] gain, input logic alc);
    exp_t e;
    e.tag = tag; e.fr = fr; e.vld = vld;
    e.smp = vld ? SAMPLE : '0;
    e.gain = gain; e.alc = alc;
    expQ.push_back(e);
    -> sampleNow;
    #0;
  endtask

  task automatic frame();
    frameClk = 1'b1; tick(4);
    frameClk = 1'b0; tick(4);
  endtask

  // Monitor: pop each expectation and compare against the ports
  initial begin
    forever begin
      @(sampleNow);
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (filterRst !== e.fr || dataValid !== e.vld || sampleOut !== e.smp ||
            appliedGain !== e.gain || alcActive !== e.alc) begin
          errors++;
          $display("FAIL %s: actual fr=%b vld=%b smp=%h gain=%h alc=%b expected fr=%b vld=%b smp=%h gain=%h alc=%b",
                   e.tag, filterRst, dataValid, sampleOut, appliedGain, alcActive,
                   e.fr, e.vld, e.smp, e.gain, e.alc);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pdnN = 1'b0; frameClk = 1'b0; hostGainWe = 1'b0;
    hostGain = '0; alcEn = 1'b0; alcGain = 8'h40; sampleIn = SAMPLE;
    tick(3);
    expect_out("R1 reset state", 1'b1, 1'b0, 8'h00, 1'b0);
    rstN = 1'b1;
    tick(3);
    expect_out("R1 power-down after reset", 1'b1, 1'b0, 8'h00, 1'b0);

    // R8: host write accepted in power-down
    hostGain = 8'h21; hostGainWe = 1'b1; tick(1); hostGainWe = 1'b0; tick(3);
    expect_out("R8 write in power-down", 1'b1, 1'b0, 8'h21, 1'b0);

    // R4: frames during power-down are not counted
    for (int i = 0; i < INIT_FRAMES + 2; i++) frame();
    expect_out("R4 frames ignored in power-down", 1'b1, 1'b0, 8'h21, 1'b0);

    // R3 / R6: release, level control enabled but held off while settling
    alcEn = 1'b1;
    pdnN = 1'b1; tick(6);
    expect_out("R3 filter released", 1'b0, 1'b0, 8'h21, 1'b0);
    for (int i = 1; i < INIT_FRAMES; i++) begin
      frame();
      expect_out("R6 settling, no valid data, no alc", 1'b0, 1'b0, 8'h21, 1'b0);
    end

    // R2 / R4: accepted power-down mid-settling discards the count
    pdnN = 1'b0; tick(10);
    expect_out("R2 long low accepted", 1'b1, 1'b0, 8'h21, 1'b0);
    pdnN = 1'b1; tick(6);
    for (int i = 1; i < INIT_FRAMES; i++) begin
      frame();
      expect_out("R4 count restarted", 1'b0, 1'b0, 8'h21, 1'b0);
    end
    frame();
    expect_out("R3 valid after last frame", 1'b0, 1'b1, 8'h40, 1'b1);

    // R5: sample path follows input when valid
    sampleIn = SAMPLE; tick(2);
    expect_out("R5 sample passes", 1'b0, 1'b1, 8'h40, 1'b1);

    // R2: short glitch is ignored
    pdnN = 1'b0; tick(2); pdnN = 1'b1; tick(8);
    expect_out("R2 short low ignored", 1'b0, 1'b1, 8'h40, 1'b1);

    // R7: host write while level control runs is held back
    hostGain = 8'h55; hostGainWe = 1'b1; tick(1); hostGainWe = 1'b0; tick(3);
    expect_out("R7 alc gain kept during write", 1'b0, 1'b1, 8'h40, 1'b1);
    alcGain = 8'h47; tick(2);
    expect_out("R7 alc gain followed", 1'b0, 1'b1, 8'h47, 1'b1);
    alcEn = 1'b0; tick(2);
    expect_out("R7 last host gain restored", 1'b0, 1'b1, 8'h55, 1'b0);
    alcEn = 1'b1; tick(2);
    expect_out("R6 alc on in normal", 1'b0, 1'b1, 8'h47, 1'b1);

    // R1 / R6: power-down while level control enabled
    pdnN = 1'b0; tick(10);
    expect_out("R1 power-down again", 1'b1, 1'b0, 8'h55, 1'b0);

    tick(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule